// File: doc/BRIEF.md
# Branch Trace Record Buffer

This block watches the retirement strobes of a two-pipe processor and turns them into compact trace records kept in a small on-chip queue. A record is written whenever a branch is taken. It holds the branch destination and the number of instructions retired in both pipes since the record before it. A debugger drains the queue through a simple read port while the program keeps running, so the executed path can be rebuilt in real time.

Long straight-line runs are folded into the instruction count, so one entry stands for many retirements. If the count would run past its field width before a branch arrives, a marker record is written instead.

Two capture policies are offered. The wrap policy overwrites the oldest entry when the queue is full, keeping the most recent history before a breakpoint. The halt policy never loses a record: when the queue fills it raises a halt request towards the debug logic and freezes capture until that request is acknowledged and room is made.

Top module: `brtrace_buf`

## Requirements
- R1: After reset the queue is empty (`rd_valid` low), `ovf_flag` is low and `halt_req` is low.
- R2: While capture is running, a record is written only in a cycle with `br_taken` high. Its target field is `br_target` of that cycle and its `rd_sat` bit is 0. Records leave the read port in the order they were written.
- R3: A record's count is the number of retire strobes (`pipe0_done`, `pipe1_done`) seen since the previous record, including those of the branch cycle itself. A cycle with both strobes adds two.
- R4: The limit is L = 2^CNT_W - 1. If, in a cycle without a branch, the running count including that cycle reaches L or more, a marker record is written with `rd_sat` = 1, target 0 and that count, and the running count restarts at zero.
- R5: `rd_valid` is high whenever the queue holds a record, and the oldest record is shown on `rd_target`, `rd_count` and `rd_sat`. A cycle with `rd_req` and `rd_valid` both high removes it. Reads work while capture runs. A write and a read in the same cycle on a full queue both take effect.
- R6: In wrap mode (`mode_sel` = 0), a write to a full queue with no read in that cycle discards the oldest record and raises `ovf_flag` one cycle later.
- R7: `ovf_flag` stays high until a cycle with `ovf_clr` high and no new overwrite. An overwrite in that same cycle keeps it high.
- R8: In halt mode (`mode_sel` = 1), `halt_req` rises after the edge at which the queue becomes full. It stays high until a cycle with `halt_ack`. If the queue is still full after the acknowledge, it rises again one cycle later. While `halt_req` is high, or while the queue is full and no read occurs, strobes are neither counted nor recorded, so no record is ever discarded.
- R9: `cap_en` is registered and takes effect one cycle later. `mode_sel` is sampled only while capture is disabled. Sampling a value different from the current mode empties the queue and clears the running count, and `halt_req` is low while capture is disabled.
- R10: While capture is disabled, the retire and branch strobes have no effect. The queue contents and the running count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe0_done | input | 1 | Instruction retired in the first pipe |
| pipe1_done | input | 1 | Instruction retired in the second pipe |
| br_taken | input | 1 | A branch was taken this cycle |
| br_target | input | ADDR_W | Destination of the taken branch |
| cap_en | input | 1 | Capture enable |
| mode_sel | input | 1 | Capture policy: 0 wrap, 1 halt on full |
| rd_req | input | 1 | Remove the oldest record |
| rd_valid | output | 1 | Queue holds at least one record |
| rd_sat | output | 1 | Oldest record is a count-limit marker |
| rd_count | output | CNT_W+1 | Instruction count of the oldest record |
| rd_target | output | ADDR_W | Target address of the oldest record |
| ovf_clr | input | 1 | Clear the sticky overwrite flag |
| ovf_flag | output | 1 | A record was discarded by an overwrite |
| halt_ack | input | 1 | Debug side acknowledges the halt request |
| halt_req | output | 1 | Request to halt the processor into the debug state |

## Verification
Every result of this block becomes visible one clock after the edge that samples its cause: a new record, a removed head, the overflow flag, the halt request and a mode flush. An enable change needs one more edge before strobes count. The bench drives each cycle's inputs mid-cycle and advances a model of the queue, running count, flags and registered enable. It compares every port 5 ns after the following rising edge, so each comparison sees exactly one register update. Sweeps cover all pairings of retire strobes against branch spacing, read rate and both policies on a four-entry queue with a three-bit count.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  typedef enum logic {
    CAP_WRAP = 1'b0,
    CAP_HALT = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/brtrace_cnt.sv
// Running retire counter and record former.
module brtrace_cnt #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              flush,
  input  logic              p0,
  input  logic              p1,
  input  logic              br,
  input  logic [ADDR_W-1:0] tgt,
  output logic              rec_wr,
  output logic              rec_sat,
  output logic [CNT_W:0]    rec_cnt,
  output logic [ADDR_W-1:0] rec_tgt
);
  localparam logic [CNT_W:0] LIM = (CNT_W+1)'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum     = {1'b0, cnt_q} + (CNT_W+1)'(p0) + (CNT_W+1)'(p1);
    rec_wr  = run && (br || (sum >= LIM));
    rec_sat = !br;
    rec_cnt = sum;
    rec_tgt = br ? tgt : '0;
    cnt_d   = cnt_q;
    if (flush)       cnt_d = '0;
    else if (rec_wr) cnt_d = '0;
    else if (run)    cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brtrace_fifo.sv
// Record queue with optional overwrite of the oldest entry.
module brtrace_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       pop_req,
  input  logic                       wrap,
  output logic                       valid,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       full_nxt,
  output logic                       pop,
  output logic                       ovwr,
  output logic [$clog2(DEPTH):0]     occ
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] DFULL = (PW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   occ_q, occ_d;
  logic          push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    valid = (occ_q != '0);
    full  = (occ_q == DFULL);
    pop   = pop_req && valid;
    ovwr  = wr && full && !pop && wrap;
    push  = wr && (!full || pop || wrap);
    wp_d  = push ? nxt(wp_q) : wp_q;
    rp_d  = (pop || ovwr) ? nxt(rp_q) : rp_q;
    occ_d = occ_q;
    if (push && !pop && !ovwr) occ_d = occ_q + 1'b1;
    else if (pop && !push)     occ_d = occ_q - 1'b1;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      occ_d = '0;
    end
    full_nxt = (occ_d == DFULL);
    rdata    = mem[rp_q];
    occ      = occ_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/brtrace_ctrl.sv
// Enable, mode, overwrite flag and halt request.
module brtrace_ctrl
  import brtrace_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_en,
  input  logic      mode_sel,
  input  logic      full,
  input  logic      full_nxt,
  input  logic      pop,
  input  logic      ovwr,
  input  logic      ovf_clr,
  input  logic      halt_ack,
  output logic      en_q,
  output cap_mode_e mode_q,
  output logic      flush,
  output logic      run,
  output logic      ovf_q,
  output logic      halt_q
);
  cap_mode_e mode_d;
  logic      halt_d, ovf_d, freeze;

  always_comb begin
    flush  = !en_q && (cap_mode_e'(mode_sel) != mode_q);
    mode_d = en_q ? mode_q : cap_mode_e'(mode_sel);
    freeze = (mode_q == CAP_HALT) && (halt_q || (full && !pop));
    run    = en_q && !freeze;
    if (!en_q || mode_q == CAP_WRAP) halt_d = 1'b0;
    else if (halt_q)                 halt_d = !halt_ack;
    else                             halt_d = full_nxt;
    if (ovwr)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= CAP_WRAP;
      halt_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      en_q   <= cap_en;
      mode_q <= mode_d;
      halt_q <= halt_d;
      ovf_q  <= ovf_d;
    end
  end
endmodule

// File: rtl/brtrace_buf.sv
module brtrace_buf
  import brtrace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe0_done,
  input  logic              pipe1_done,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              cap_en,
  input  logic              mode_sel,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic              rd_sat,
  output logic [CNT_W:0]    rd_count,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              ovf_clr,
  output logic              ovf_flag,
  input  logic              halt_ack,
  output logic              halt_req
);
  localparam int REC_W = 1 + (CNT_W + 1) + ADDR_W;
  localparam int OW    = $clog2(DEPTH) + 1;

  logic [1:0]        rs_q;
  logic              rst_s;
  logic              en_q, flush, run, full, full_nxt, pop, ovwr;
  cap_mode_e         mode_q;
  logic              rec_wr, rec_sat;
  logic [CNT_W:0]    rec_cnt;
  logic [ADDR_W-1:0] rec_tgt;
  logic [REC_W-1:0]  head;
  logic [OW-1:0]     occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  brtrace_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_s), .cap_en(cap_en), .mode_sel(mode_sel),
    .full(full), .full_nxt(full_nxt), .pop(pop), .ovwr(ovwr),
    .ovf_clr(ovf_clr), .halt_ack(halt_ack), .en_q(en_q), .mode_q(mode_q),
    .flush(flush), .run(run), .ovf_q(ovf_flag), .halt_q(halt_req)
  );

  brtrace_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_s), .run(run), .flush(flush),
    .p0(pipe0_done), .p1(pipe1_done), .br(br_taken), .tgt(br_target),
    .rec_wr(rec_wr), .rec_sat(rec_sat), .rec_cnt(rec_cnt), .rec_tgt(rec_tgt)
  );

  brtrace_fifo #(.W(REC_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_s), .flush(flush), .wr(rec_wr),
    .wdata({rec_sat, rec_cnt, rec_tgt}), .pop_req(rd_req),
    .wrap(mode_q == CAP_WRAP), .valid(rd_valid), .rdata(head),
    .full(full), .full_nxt(full_nxt), .pop(pop), .ovwr(ovwr), .occ(occ)
  );

  assign {rd_sat, rd_count, rd_target} = head;
endmodule

// File: rtl/brtrace_chk.sv
module brtrace_chk #(
  parameter int CNT_W = 6,
  parameter int DEPTH = 8,
  parameter int OW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_q,
  input logic           mode_q,
  input logic           flush,
  input logic           rec_wr,
  input logic [CNT_W:0] rec_cnt,
  input logic           full,
  input logic           pop,
  input logic           ovwr,
  input logic [OW-1:0]  occ,
  input logic           rd_valid,
  input logic           ovf_flag,
  input logic           ovf_clr,
  input logic           halt_req,
  input logic           halt_ack
);
  localparam logic [CNT_W:0] CMAX = (CNT_W+1)'(1 << CNT_W);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr |-> (rec_cnt <= CMAX));
  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovwr |=> ovf_flag);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R8
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q) |-> !(rec_wr && full && !pop));
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !halt_ack && en_q && mode_q) |=> halt_req);
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !rec_wr);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(mode_q));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_valid);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !rec_wr);
endmodule

bind brtrace_buf brtrace_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_s), .en_q(en_q), .mode_q(mode_q), .flush(flush),
  .rec_wr(rec_wr), .rec_cnt(rec_cnt), .full(full), .pop(pop), .ovwr(ovwr),
  .occ(occ), .rd_valid(rd_valid), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
  .halt_req(halt_req), .halt_ack(halt_ack)
);

// File: tb/brtrace_buf_tb_top.sv
`timescale 1ns/1ps
module brtrace_buf_tb_top;
  localparam int AW = 8;
  localparam int CW = 3;
  localparam int D  = 4;
  localparam int L  = (1 << CW) - 1;

  logic          clk, rst_n;
  logic          p0, p1, br, en, msel, rd, clr, ack;
  logic [AW-1:0] tgt;
  logic          rd_valid, rd_sat, ovf_flag, halt_req;
  logic [CW:0]   rd_count;
  logic [AW-1:0] rd_target;

  int n_chk, n_bad;
  int qt[D], qc[D], qs[D];
  int m_occ, m_cnt, m_ovf, m_halt, m_en, m_mode;

  brtrace_buf #(.ADDR_W(AW), .CNT_W(CW), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .pipe0_done(p0), .pipe1_done(p1),
    .br_taken(br), .br_target(tgt), .cap_en(en), .mode_sel(msel),
    .rd_req(rd), .rd_valid(rd_valid), .rd_sat(rd_sat), .rd_count(rd_count),
    .rd_target(rd_target), .ovf_clr(clr), .ovf_flag(ovf_flag),
    .halt_ack(ack), .halt_req(halt_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rd_valid", int'(rd_valid), int'(m_occ > 0));
    if (m_occ > 0) begin
      chk(tag, "rd_target", int'(rd_target), qt[0]);
      chk(tag, "rd_count", int'(rd_count), qc[0]);
      chk(tag, "rd_sat", int'(rd_sat), qs[0]);
    end
    chk(tag, "ovf_flag", int'(ovf_flag), m_ovf);
    chk(tag, "halt_req", int'(halt_req), m_halt);
  endtask

  task automatic qpop();
    for (int k = 0; k < D - 1; k++) begin
      qt[k] = qt[k+1]; qc[k] = qc[k+1]; qs[k] = qs[k+1];
    end
    m_occ--;
  endtask

  task automatic step(input string tag, input int a, input int b, input int bt,
                      input int t, input int r, input int c, input int k,
                      input int e, input int m);
    int pop, frz, sum, w, ov;
    p0 = a[0]; p1 = b[0]; br = bt[0]; tgt = t[AW-1:0]; rd = r[0];
    clr = c[0]; ack = k[0]; en = e[0]; msel = m[0];
    pop = (r != 0 && m_occ > 0) ? 1 : 0;
    if (m_en == 0) begin
      if (pop != 0) qpop();
      if (m != m_mode) begin m_occ = 0; m_cnt = 0; end
      m_mode = m;
      if (c != 0) m_ovf = 0;
      m_halt = 0;
    end else begin
      frz = (m_mode != 0 && (m_halt != 0 || (m_occ == D && pop == 0))) ? 1 : 0;
      w = 0; ov = 0; sum = 0;
      if (frz == 0) begin
        sum = m_cnt + a + b;
        if (bt != 0 || sum >= L) begin w = 1; m_cnt = 0; end
        else m_cnt = sum;
      end
      if (pop != 0) qpop();
      if (w != 0) begin
        if (m_occ == D) begin qpop(); ov = 1; end
        qt[m_occ] = (bt != 0) ? (t & 255) : 0;
        qc[m_occ] = sum;
        qs[m_occ] = (bt != 0) ? 0 : 1;
        m_occ++;
      end
      if (ov != 0) m_ovf = 1;
      else if (c != 0) m_ovf = 0;
      if (m_mode == 0) m_halt = 0;
      else if (m_halt != 0) m_halt = (k != 0) ? 0 : 1;
      else m_halt = (m_occ == D) ? 1 : 0;
    end
    m_en = e;
    @(posedge clk);
    #5;
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    m_occ = 0; m_cnt = 0; m_ovf = 0; m_halt = 0; m_en = 0; m_mode = 0;
    p0 = 0; p1 = 0; br = 0; tgt = '0; rd = 0; clr = 0; ack = 0; en = 0; msel = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    compare("R1");

    // R10: strobes while disabled are ignored
    for (int i = 0; i < 8; i++) step("R10", i & 1, (i >> 1) & 1, 1, i + 3, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R3: all strobe pairings against branch spacing, reads every other cycle
    for (int i = 0; i < 64; i++)
      step("R3", i & 1, (i >> 1) & 1, (i % 4 == 3) ? 1 : 0, (i * 37) & 255, i & 1, 0, 0, 1, 0);
    // R2: irregular branches with draining
    for (int i = 0; i < 40; i++)
      step("R2", (i >> 2) & 1, i & 1, (i % 3 != 1) ? 1 : 0, (i * 11 + 5) & 255, 1, 0, 0, 1, 0);
    // R4: long runs without branches create limit markers
    for (int i = 0; i < 45; i++)
      step("R4", 1, (i % 5 != 2) ? 1 : 0, (i % 9 == 8) ? 1 : 0, (i * 3) & 255, (i % 3 != 0) ? 1 : 0, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) step("R5", 0, 0, 0, 0, 1, 0, 0, 1, 0);
    // R6: fill and overwrite in wrap mode
    for (int i = 0; i < 10; i++) step("R6", 0, 1, 1, 100 + i, 0, 0, 0, 1, 0);
    // R5: write and read together on a full queue
    for (int i = 0; i < 4; i++) step("R5", 1, 0, 1, 150 + i, 1, 0, 0, 1, 0);
    // R7: clear together with an overwrite keeps the flag, then clear alone drops it
    step("R7", 0, 0, 1, 77, 0, 1, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R9: mode change while enabled is ignored; while disabled it flushes
    step("R9", 1, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R9", 0, 0, 1, 9, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R8: fill in halt mode, stay frozen, drain, acknowledge
    for (int i = 0; i < 8; i++) step("R8", 1, 1, 1, 200 + i, 0, 0, 0, 1, 1);
    step("R8", 1, 0, 1, 30, 0, 0, 1, 1, 1);
    step("R8", 1, 0, 1, 31, 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) step("R8", 1, 1, 1, 40 + i, 1, 0, 0, 1, 1);
    step("R8", 0, 1, 1, 50, 1, 0, 1, 1, 1);
    for (int i = 0; i < 30; i++)
      step("R8", i & 1, (i >> 1) & 1, (i % 2 == 0) ? 1 : 0, 60 + i, (i % 3 == 0) ? 1 : 0, 0, (i % 5 == 4) ? 1 : 0, 1, 1);
    // R2: order in halt mode with steady draining
    for (int i = 0; i < 20; i++)
      step("R2", 1, i & 1, 1, (i * 13) & 255, 1, 0, 0, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule